// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a byte-wide parallel NOR-style flash interface. It watches every bus write (address and data) and tracks the unlock-prefixed command sequences that select what the device does next. The supported commands are: return to array reads, enter identification (autoselect) reads, program one byte, erase the whole chip, and erase one sector. A sector erase can also be paused and continued by single writes that need no unlock prefix.

When a sequence completes, the block issues a one-cycle operation request. The request carries the operation kind and the latched address and data. The embedded algorithm that performs the operation runs outside this block and reports its end on `op_done_i`. A two-bit mode output tells the read path what reads should return. In identification mode, this block answers reads itself with fixed ID bytes and per-sector protection flags.

Only the low eleven address bits take part in unlock address matching. The three top address bits select one of eight sectors.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode_o` is 0 (array read; encodings: 0 array, 1 identification, 2 busy, 3 suspended) and `op_start_o`, `susp_o` and `resume_o` are low.
- R2: A write of F0h at any address while in identification mode returns `mode_o` to 0. The unlock prefix (AAh at 555h, then 55h at 2AAh) followed by F0h at 555h leaves `mode_o` at 0.
- R3: The unlock prefix followed by 90h at 555h sets `mode_o` to 1. In that mode, `rd_data_o` is 7Fh for read offset 00h and 20h for read offset 01h, where the offset is `rd_addr_i[7:0]`. `rd_data_o` is 00h whenever `mode_o` is not 1.
- R4: In identification mode, read offset 02h returns 01h if bit `rd_addr_i[16:14]` of `sect_prot_i` is set, and 00h otherwise.
- R5: The unlock prefix followed by A0h at 555h, then any write, pulses `op_start_o` one cycle after that write. The pulse carries `op_kind_o`=0 (program), with `op_addr_o` and `op_data_o` equal to that write's address and data, and `mode_o` becomes 2.
- R6: The unlock prefix, 80h at 555h, the unlock prefix again, then 10h at 555h, pulses `op_start_o` with `op_kind_o`=1 (chip erase) and sets `mode_o` to 2.
- R7: The same erase prefix followed by 30h at any address pulses `op_start_o` with `op_kind_o`=2 (sector erase) and `op_addr_o` equal to that write's address, and sets `mode_o` to 2.
- R8: Any write that breaks an expected address/data step returns the sequence to array mode without starting an operation. A later write that would have completed the broken sequence starts nothing.
- R9: While `mode_o` is 2, writes other than B0h during a sector erase neither start an operation nor change the mode. A pulse on `op_done_i` returns `mode_o` to 0.
- R10: During a sector erase, B0h at any address pulses `susp_o` and sets `mode_o` to 3. While suspended, 30h at any address pulses `resume_o` and sets `mode_o` back to 2.
- R11: B0h and 30h written while no sector erase is active or suspended produce no `susp_o` or `resume_o` pulse and leave `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | One bus write this cycle |
| wr_addr_i | input | 17 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 17 | Read address for identification reads |
| sect_prot_i | input | 8 | Protection flag per sector |
| op_done_i | input | 1 | Embedded operation finished |
| mode_o | output | 2 | 0 array, 1 identification, 2 busy, 3 suspended |
| rd_data_o | output | 8 | Identification read data |
| op_start_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 2 | 0 program, 1 chip erase, 2 sector erase |
| op_addr_o | output | 17 | Latched operation address |
| op_data_o | output | 8 | Latched program data |
| susp_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |

## Verification
A sequence tracker stuck in the wrong step becomes visible at the write that should complete the command. Either `op_start_o` fails to pulse in the following cycle, or it pulses after a broken prefix, so the error shows one cycle after the completing write. A wrong busy or suspend state shows up on `mode_o` in the cycle after the write or `op_done_i` that caused it. It also shows as a missing or spurious `susp_o`/`resume_o` pulse on the next B0h or 30h write. A wrong identification mux shows combinationally on `rd_data_o` for the offending read offset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_ARRAY,
        S_UNL1,
        S_UNL2,
        S_IDENT,
        S_PGM_WAIT,
        S_ERS_UNL0,
        S_ERS_UNL1,
        S_ERS_UNL2,
        S_BUSY_PGM,
        S_BUSY_CHIP,
        S_BUSY_SECT,
        S_SUSPENDED
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_BUSY  = 2'd2,
        MODE_SUSP  = 2'd3
    } dev_mode_e;

    typedef enum logic [1:0] {
        OPK_PROGRAM = 2'd0,
        OPK_CHIP    = 2'd1,
        OPK_SECTOR  = 2'd2
    } op_kind_e;

    localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B  = 8'h55;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_PGM     = 8'hA0;
    localparam logic [7:0] CMD_ERS     = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int UNLOCK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              op_done_i,
    output dev_mode_e         mode_o,
    output logic              op_start_o,
    output op_kind_e          op_kind_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [DATA_W-1:0] op_data_o,
    output logic              susp_o,
    output logic              resume_o
);

    localparam logic [UNLOCK_W-1:0] ADDR_FIRST  = UNLOCK_W'('h555);
    localparam logic [UNLOCK_W-1:0] ADDR_SECOND = UNLOCK_W'('h2AA);

    typedef struct packed {
        seq_state_e        state;
        logic              start;
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              susp;
        logic              resume;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    logic at_first, at_second;
    logic is_unlk_a, is_unlk_b;

    assign at_first  = (wr_addr_i[UNLOCK_W-1:0] == ADDR_FIRST);
    assign at_second = (wr_addr_i[UNLOCK_W-1:0] == ADDR_SECOND);
    assign is_unlk_a = at_first  && (wr_data_i == DATA_W'(CMD_UNLK_A));
    assign is_unlk_b = at_second && (wr_data_i == DATA_W'(CMD_UNLK_B));

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.susp   = 1'b0;
        r_d.resume = 1'b0;
        unique case (r_q.state)
            S_ARRAY: begin
                if (wr_en_i && is_unlk_a) r_d.state = S_UNL1;
            end
            S_IDENT: begin
                if (wr_en_i) r_d.state = is_unlk_a ? S_UNL1 : S_ARRAY;
            end
            S_UNL1: begin
                if (wr_en_i) r_d.state = is_unlk_b ? S_UNL2 : S_ARRAY;
            end
            S_UNL2: begin
                if (wr_en_i) begin
                    r_d.state = S_ARRAY;
                    if (at_first) begin
                        if (wr_data_i == DATA_W'(CMD_IDENT)) r_d.state = S_IDENT;
                        else if (wr_data_i == DATA_W'(CMD_PGM)) r_d.state = S_PGM_WAIT;
                        else if (wr_data_i == DATA_W'(CMD_ERS)) r_d.state = S_ERS_UNL0;
                    end
                end
            end
            S_PGM_WAIT: begin
                if (wr_en_i) begin
                    r_d.state = S_BUSY_PGM;
                    r_d.start = 1'b1;
                    r_d.kind  = OPK_PROGRAM;
                    r_d.addr  = wr_addr_i;
                    r_d.data  = wr_data_i;
                end
            end
            S_ERS_UNL0: begin
                if (wr_en_i) r_d.state = is_unlk_a ? S_ERS_UNL1 : S_ARRAY;
            end
            S_ERS_UNL1: begin
                if (wr_en_i) r_d.state = is_unlk_b ? S_ERS_UNL2 : S_ARRAY;
            end
            S_ERS_UNL2: begin
                if (wr_en_i) begin
                    r_d.state = S_ARRAY;
                    if (at_first && wr_data_i == DATA_W'(CMD_CHIP)) begin
                        r_d.state = S_BUSY_CHIP;
                        r_d.start = 1'b1;
                        r_d.kind  = OPK_CHIP;
                        r_d.addr  = wr_addr_i;
                        r_d.data  = wr_data_i;
                    end else if (wr_data_i == DATA_W'(CMD_SECT)) begin
                        r_d.state = S_BUSY_SECT;
                        r_d.start = 1'b1;
                        r_d.kind  = OPK_SECTOR;
                        r_d.addr  = wr_addr_i;
                        r_d.data  = wr_data_i;
                    end
                end
            end
            S_BUSY_PGM, S_BUSY_CHIP: begin
                if (op_done_i) r_d.state = S_ARRAY;
            end
            S_BUSY_SECT: begin
                if (op_done_i) begin
                    r_d.state = S_ARRAY;
                end else if (wr_en_i && wr_data_i == DATA_W'(CMD_SUSPEND)) begin
                    r_d.state = S_SUSPENDED;
                    r_d.susp  = 1'b1;
                end
            end
            S_SUSPENDED: begin
                if (wr_en_i && wr_data_i == DATA_W'(CMD_RESUME)) begin
                    r_d.state  = S_BUSY_SECT;
                    r_d.resume = 1'b1;
                end
            end
            default: r_d.state = S_ARRAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= S_ARRAY;
            r_q.start  <= 1'b0;
            r_q.kind   <= OPK_PROGRAM;
            r_q.addr   <= '0;
            r_q.data   <= '0;
            r_q.susp   <= 1'b0;
            r_q.resume <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            S_IDENT:                              mode_o = MODE_IDENT;
            S_BUSY_PGM, S_BUSY_CHIP, S_BUSY_SECT: mode_o = MODE_BUSY;
            S_SUSPENDED:                          mode_o = MODE_SUSP;
            default:                              mode_o = MODE_ARRAY;
        endcase
    end

    assign op_start_o = r_q.start;
    assign op_kind_o  = r_q.kind;
    assign op_addr_o  = r_q.addr;
    assign op_data_o  = r_q.data;
    assign susp_o     = r_q.susp;
    assign resume_o   = r_q.resume;

    // R5: a request follows a bus write in the cycle before
    assert_start_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |-> $past(wr_en_i));

    // R8: a request only comes out of a completed sequence step
    assert_start_from_final_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |-> ($past(r_q.state) == S_PGM_WAIT || $past(r_q.state) == S_ERS_UNL2));

    // R9: a running program holds until done
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_BUSY_PGM && !op_done_i) |=> (r_q.state == S_BUSY_PGM));

    // R10: suspend pulse coincides with suspended mode
    assert_susp_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> (mode_o == MODE_SUSP));

    // R11: suspend only out of an active sector erase
    assert_susp_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> ($past(r_q.state) == S_BUSY_SECT));

    // R11: resume only out of the suspended state
    assert_resume_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> ($past(r_q.state) == S_SUSPENDED));

    // R1: at most one event pulse per cycle
    assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_start_o, susp_o, resume_o}));

endmodule

// File: rtl/flash_id_resp.sv
module flash_id_resp
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 17,
    parameter int          DATA_W = 8,
    parameter int          N_SECT = 8,
    parameter logic [7:0]  MFR_ID = 8'h7F,
    parameter logic [7:0]  DEV_ID = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dev_mode_e         mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [N_SECT-1:0] sect_prot_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int SECT_W = $clog2(N_SECT);

    logic [SECT_W-1:0] sect_idx;
    logic [7:0]        offset;

    assign sect_idx = rd_addr_i[ADDR_W-1 -: SECT_W];
    assign offset   = rd_addr_i[7:0];

    always_comb begin
        rd_data_o = '0;
        if (mode_i == MODE_IDENT) begin
            unique case (offset)
                8'h00:   rd_data_o = DATA_W'(MFR_ID);
                8'h01:   rd_data_o = DATA_W'(DEV_ID);
                8'h02:   rd_data_o = DATA_W'(sect_prot_i[sect_idx]);
                default: rd_data_o = '0;
            endcase
        end
    end

    // R3: no identification data outside identification mode
    assert_quiet_outside_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_IDENT) |-> (rd_data_o == '0));

    // R4: protection reads are 0 or 1
    assert_prot_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IDENT && offset == 8'h02) |-> (rd_data_o[DATA_W-1:1] == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         DATA_W   = 8,
    parameter int         N_SECT   = 8,
    parameter int         UNLOCK_W = 11,
    parameter logic [7:0] MFR_ID   = 8'h7F,
    parameter logic [7:0] DEV_ID   = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [N_SECT-1:0] sect_prot_i,
    input  logic              op_done_i,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              op_start_o,
    output logic [1:0]        op_kind_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [DATA_W-1:0] op_data_o,
    output logic              susp_o,
    output logic              resume_o
);

    dev_mode_e mode_w;
    op_kind_e  kind_w;

    flash_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .UNLOCK_W (UNLOCK_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .op_done_i  (op_done_i),
        .mode_o     (mode_w),
        .op_start_o (op_start_o),
        .op_kind_o  (kind_w),
        .op_addr_o  (op_addr_o),
        .op_data_o  (op_data_o),
        .susp_o     (susp_o),
        .resume_o   (resume_o)
    );

    flash_id_resp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_SECT (N_SECT),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_id (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_w),
        .rd_addr_i   (rd_addr_i),
        .sect_prot_i (sect_prot_i),
        .rd_data_o   (rd_data_o)
    );

    assign mode_o    = mode_w;
    assign op_kind_o = kind_w;

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [16:0] rd_addr = '0;
    logic [7:0]  sect_prot = 8'b1010_0100;
    logic        op_done = 1'b0;
    logic [1:0]  mode;
    logic [7:0]  rd_data;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic        susp;
    logic        resume;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .sect_prot_i (sect_prot),
        .op_done_i   (op_done),
        .mode_o      (mode),
        .rd_data_o   (rd_data),
        .op_start_o  (op_start),
        .op_kind_o   (op_kind),
        .op_addr_o   (op_addr),
        .op_data_o   (op_data),
        .susp_o      (susp),
        .resume_o    (resume)
    );

    // entry: {address, data, expected mode, expected op_start}
    localparam int NV = 16;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {17'h00555, 8'hAA, 2'd0, 1'b0},   // R2 unlock then reset command
        {17'h002AA, 8'h55, 2'd0, 1'b0},
        {17'h00555, 8'hF0, 2'd0, 1'b0},
        {17'h00555, 8'hAA, 2'd0, 1'b0},   // R3 enter identification
        {17'h002AA, 8'h55, 2'd0, 1'b0},
        {17'h00555, 8'h90, 2'd1, 1'b0},
        {17'h01234, 8'hF0, 2'd0, 1'b0},   // R2 single reset write
        {17'h00555, 8'hAA, 2'd0, 1'b0},   // R8 broken second step
        {17'h002AB, 8'h55, 2'd0, 1'b0},
        {17'h002AA, 8'h55, 2'd0, 1'b0},
        {17'h00555, 8'hA0, 2'd0, 1'b0},
        {17'h00010, 8'h33, 2'd0, 1'b0},   // R8 no program started
        {17'h00555, 8'hAA, 2'd0, 1'b0},   // R8 wrong command byte
        {17'h002AA, 8'h55, 2'd0, 1'b0},
        {17'h00555, 8'h77, 2'd0, 1'b0},
        {17'h00020, 8'h44, 2'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        bus_write(17'h00555, 8'hAA);
        bus_write(17'h002AA, 8'h55);
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", 32'(mode), 32'd0);
        chk("R1 pulses", 32'({op_start, susp, resume}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][27:11], VEC[i][10:3]);
            chk($sformatf("R2/R3/R8 vec%0d mode", i), 32'(mode), 32'(VEC[i][2:1]));
            chk($sformatf("R8 vec%0d start", i), 32'(op_start), 32'(VEC[i][0]));
        end

        // identification reads
        unlock();
        bus_write(17'h00555, 8'h90);
        chk("R3 ident mode", 32'(mode), 32'd1);
        rd_addr = 17'h00000; #1;
        chk("R3 manufacturer", 32'(rd_data), 32'h7F);
        rd_addr = 17'h00001; #1;
        chk("R3 device", 32'(rd_data), 32'h20);
        rd_addr = 17'h08002; #1;
        chk("R4 sector2 protected", 32'(rd_data), 32'h01);
        rd_addr = 17'h04002; #1;
        chk("R4 sector1 open", 32'(rd_data), 32'h00);
        rd_addr = 17'h1C002; #1;
        chk("R4 sector7 protected", 32'(rd_data), 32'h01);
        bus_write(17'h00000, 8'hF0);
        chk("R2 exit ident", 32'(mode), 32'd0);
        rd_addr = 17'h00000; #1;
        chk("R3 quiet in array mode", 32'(rd_data), 32'h00);

        // program
        unlock();
        bus_write(17'h00555, 8'hA0);
        chk("R5 no start yet", 32'(op_start), 32'd0);
        bus_write(17'h0ABCD, 8'h5A);
        chk("R5 start", 32'(op_start), 32'd1);
        chk("R5 kind", 32'(op_kind), 32'd0);
        chk("R5 addr", 32'(op_addr), 32'h0ABCD);
        chk("R5 data", 32'(op_data), 32'h5A);
        chk("R5 mode busy", 32'(mode), 32'd2);
        @(negedge clk);
        chk("R5 start single cycle", 32'(op_start), 32'd0);
        unlock();
        bus_write(17'h00555, 8'hA0);
        bus_write(17'h00100, 8'h11);
        chk("R9 busy ignores program", 32'(op_start), 32'd0);
        chk("R9 busy mode kept", 32'(mode), 32'd2);
        chk("R9 addr kept", 32'(op_addr), 32'h0ABCD);
        bus_write(17'h00000, 8'hF0);
        chk("R9 busy ignores reset", 32'(mode), 32'd2);
        finish_op();
        chk("R9 done to array", 32'(mode), 32'd0);

        // chip erase
        unlock();
        bus_write(17'h00555, 8'h80);
        unlock();
        bus_write(17'h00555, 8'h10);
        chk("R6 start", 32'(op_start), 32'd1);
        chk("R6 kind", 32'(op_kind), 32'd1);
        chk("R6 mode", 32'(mode), 32'd2);
        bus_write(17'h00000, 8'hB0);
        chk("R11 no suspend in chip erase", 32'(susp), 32'd0);
        chk("R11 mode kept", 32'(mode), 32'd2);
        finish_op();
        chk("R9 chip done", 32'(mode), 32'd0);

        // broken erase prefix
        unlock();
        bus_write(17'h00555, 8'h80);
        bus_write(17'h00555, 8'hAA);
        bus_write(17'h00255, 8'h55);
        bus_write(17'h00555, 8'h10);
        chk("R8 broken erase no start", 32'(op_start), 32'd0);
        chk("R8 broken erase mode", 32'(mode), 32'd0);

        // sector erase, suspend, resume
        unlock();
        bus_write(17'h00555, 8'h80);
        unlock();
        bus_write(17'h0C000, 8'h30);
        chk("R7 start", 32'(op_start), 32'd1);
        chk("R7 kind", 32'(op_kind), 32'd2);
        chk("R7 addr", 32'(op_addr), 32'h0C000);
        chk("R7 mode", 32'(mode), 32'd2);
        bus_write(17'h00000, 8'h30);
        chk("R11 no resume while running", 32'(resume), 32'd0);
        bus_write(17'h1F0F0, 8'hB0);
        chk("R10 suspend pulse", 32'(susp), 32'd1);
        chk("R10 suspended mode", 32'(mode), 32'd3);
        @(negedge clk);
        chk("R10 suspend pulse single", 32'(susp), 32'd0);
        bus_write(17'h00000, 8'hB0);
        chk("R11 no second suspend", 32'(susp), 32'd0);
        bus_write(17'h12345, 8'h30);
        chk("R10 resume pulse", 32'(resume), 32'd1);
        chk("R10 resumed mode", 32'(mode), 32'd2);
        finish_op();
        chk("R9 sector done", 32'(mode), 32'd0);

        // suspend and resume with nothing to act on
        bus_write(17'h00000, 8'hB0);
        chk("R11 idle suspend ignored", 32'(susp), 32'd0);
        chk("R11 idle mode", 32'(mode), 32'd0);
        bus_write(17'h00000, 8'h30);
        chk("R11 idle resume ignored", 32'(resume), 32'd0);

        // reset mid-sequence
        unlock();
        bus_write(17'h00555, 8'hA0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_write(17'h00040, 8'h12);
        chk("R1 reset clears sequence", 32'(op_start), 32'd0);
        chk("R1 reset mode", 32'(mode), 32'd0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule